// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit channel of a programmable interval timer. The channel advances only on cycles in which the count-enable strobe is high. The strobe is derived elsewhere from the timer input clock. A load strobe writes a new initial count and a 3-bit counting mode in a single cycle. The channel then drives its output waveform according to that mode and shows the remaining count on a 16-bit bus. A separate access block can sample that bus for latching.

Six counting behaviours are provided, in binary only:
- an interrupt-on-terminal-count level;
- a gate-triggered one-shot;
- a rate generator with a one-tick low pulse each period;
- a square wave;
- a software-triggered strobe;
- a gate-triggered strobe.

The gate input either pauses counting or restarts it on a rising edge, depending on the mode. Host register decoding, latching, BCD and interrupt routing are not part of this block.

Top module: `pit_channel`

## Requirements
- R1: A loaded count of 0 is taken as 65536. After such a load, count_o reads 0 and OUT first changes only after 65536 counted ticks (in mode 0: low for 65535 ticks, high after the 65536th).
- R2: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R3: Mode 0: OUT is low from the load and goes high once the counted ticks reach the loaded count N. It then stays high, and count_o holds 0, until the next load.
- R4: Mode 1: OUT is low while counting and high once N ticks have elapsed. A rising gate edge restarts counting from N. A low gate does not pause counting.
- R5: Mode 2: the period is N ticks. OUT is low only while N-1 ticks of the current period have elapsed. After N ticks the count reloads to N and OUT returns high. A rising gate edge restarts the period.
- R6: Mode 3: OUT is high for the first (N+1)/2 ticks (integer division) of each N-tick period and low for the rest. The count reloads automatically, and a rising gate edge restarts the period.
- R7: Mode 4: OUT is low except for exactly one tick, high once N ticks have elapsed. After that it stays low until the next load.
- R8: Mode 5: strobe behaviour as in mode 4, but a rising gate edge restarts counting from N, and a low gate does not pause counting.
- R9: In modes 0, 2, 3 and 4, ticks arriving while gate_i is low are ignored, and count_o holds its value.
- R10: After reset the channel is in mode 3 with a count of 65536: count_o reads 0 and OUT is high.
- R11: count_o shows N minus the ticks elapsed in the current period, truncated to 16 bits. It is 0 after a one-shot mode has expired.
- R12: A load restarts the channel from the new count on the following cycle. A load has priority over a tick or a gate edge in the same cycle, and the next cycle shows count_o equal to the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-enable strobe, one tick per high cycle |
| gate_i | input | 1 | Gate level, synchronous to clk_i |
| load_i | input | 1 | Load strobe for count and mode |
| load_count_i | input | 16 | Initial count, 0 meaning 65536 |
| load_mode_i | input | 3 | Counting mode code 0 to 7 |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Live remaining count |

## Verification
The assertions assume that gate_i, cnt_en_i and load_i are synchronous to clk_i, with no metastable sampling. They also assume that the mode and count fields matter only in cycles in which load_i is high. The properties on rate and strobe modes further assume a loaded count of at least 2, so that the low pulse and the strobe fall on distinct ticks. The bench changes every input on the falling clock edge and loads only counts of 2 or more, plus the 0 (65536) case. It toggles the gate with at least one full cycle at each level, so every edge is seen by the registered detector.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic mode_e norm_mode(input logic [2:0] code);
    if (code[2] && code[1]) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

  function automatic logic gate_pauses(input mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTB);
  endfunction

  function automatic logic gate_retrig(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pit_elapsed.sv
module pit_elapsed
  import pit_pkg::*;
#(
  parameter int unsigned EW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          rise_i,
  input  logic          tick_i,
  input  logic          gate_i,
  input  mode_e         mode_i,
  input  logic [EW-1:0] reload_i,
  output logic [EW-1:0] elapsed_o
);
  logic [EW-1:0] elapsed_q, elapsed_d;
  logic          run;

  assign run = !gate_pauses(mode_i) || gate_i;

  always_comb begin
    elapsed_d = elapsed_q;
    if (load_i) begin
      elapsed_d = '0;
    end else if (rise_i && gate_retrig(mode_i)) begin
      elapsed_d = '0;
    end else if (tick_i && run) begin
      if (is_periodic(mode_i)) begin
        elapsed_d = (elapsed_q == reload_i - 1'b1) ? '0 : elapsed_q + 1'b1;
      end else if ((mode_i == M_TERM) || (mode_i == M_ONESHOT)) begin
        // saturate at terminal count
        if (elapsed_q < reload_i) elapsed_d = elapsed_q + 1'b1;
      end else begin
        // strobe modes stop one past terminal count
        if (elapsed_q <= reload_i) elapsed_d = elapsed_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elapsed_q <= '0;
    else         elapsed_q <= elapsed_d;
  end

  assign elapsed_o = elapsed_q;
endmodule

// File: rtl/pit_out_dec.sv
module pit_out_dec
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned EW = CNT_W + 1
) (
  input  mode_e            mode_i,
  input  logic [EW-1:0]    reload_i,
  input  logic [EW-1:0]    elapsed_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  logic [EW:0]   half;
  logic [EW-1:0] remain;

  assign half   = ({1'b0, reload_i} + 1'b1) >> 1;
  assign remain = (reload_i > elapsed_i) ? reload_i - elapsed_i : '0;
  assign count_o = remain[CNT_W-1:0];

  always_comb begin
    unique case (mode_i)
      M_TERM, M_ONESHOT: out_o = (elapsed_i >= reload_i);
      M_RATE:            out_o = (elapsed_i != reload_i - 1'b1);
      M_SQUARE:          out_o = ({1'b0, elapsed_i} < half);
      default:           out_o = (elapsed_i == reload_i);
    endcase
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_count_i,
  input  logic [2:0]       load_mode_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned EW = CNT_W + 1;
  localparam logic [EW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  mode_e         mode_q;
  logic [EW-1:0] reload_q;
  logic [EW-1:0] elapsed;
  logic          rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_SQUARE;
      reload_q <= FULL;
    end else if (load_i) begin
      mode_q   <= norm_mode(load_mode_i);
      reload_q <= (load_count_i == '0) ? FULL : {1'b0, load_count_i};
    end
  end

  pit_gate_edge u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (rise)
  );

  pit_elapsed #(.EW(EW)) u_elapsed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .rise_i    (rise),
    .tick_i    (cnt_en_i),
    .gate_i    (gate_i),
    .mode_i    (mode_q),
    .reload_i  (reload_q),
    .elapsed_o (elapsed)
  );

  pit_out_dec #(.CNT_W(CNT_W)) u_dec (
    .mode_i    (mode_q),
    .reload_i  (reload_q),
    .elapsed_i (elapsed),
    .out_o     (out_o),
    .count_o   (count_o)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned EW = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             gate_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_count_i,
  input logic [2:0]       load_mode_i,
  input logic             out_o,
  input logic [CNT_W-1:0] count_o,
  input logic [2:0]       mode_q,
  input logic [EW-1:0]    reload_q
);
  a_r1_zero_is_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (load_count_i == '0) |=> reload_q == {1'b1, {CNT_W{1'b0}}});

  a_r2_alias_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && load_mode_i[2] && load_mode_i[1] |=> mode_q == {1'b0, $past(load_mode_i[1:0])});

  a_r3_term_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd0) && out_o && !load_i |=> out_o);

  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd4) && out_o && cnt_en_i && gate_i && !load_i |=> !out_o);

  a_r8_hw_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd5) && out_o && cnt_en_i && !load_i |=> !out_o);

  a_r9_gate_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i && !load_i && (mode_q inside {3'd0, 3'd2, 3'd3, 3'd4}) |=> $stable(count_o));

  a_r12_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_count_i));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_en_i     (cnt_en_i),
  .gate_i       (gate_i),
  .load_i       (load_i),
  .load_count_i (load_count_i),
  .load_mode_i  (load_mode_i),
  .out_o        (out_o),
  .count_o      (count_o),
  .mode_q       (mode_q),
  .reload_q     (reload_q)
);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b1;
  logic        load = 1'b0;
  logic [15:0] load_count = '0;
  logic [2:0]  load_mode = '0;
  logic        out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pit_channel dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cnt_en_i     (cnt_en),
    .gate_i       (gate),
    .load_i       (load),
    .load_count_i (load_count),
    .load_mode_i  (load_mode),
    .out_o        (out),
    .count_o      (count)
  );

  task automatic chk_out(input string req, input logic exp);
    checks++;
    if (out !== exp) begin
      errors++;
      $display("FAIL %s out actual %0b expected %0b", req, out, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input logic [15:0] exp);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s count actual %0d expected %0d", req, count, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] n);
    @(negedge clk);
    load = 1'b1; load_mode = m; load_count = n;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic gate_pulse();
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_cnt("R10", 16'd0);
    chk_out("R10", 1'b1);
  endtask

  task automatic t_mode0();
    gate = 1'b1;
    do_load(3'd0, 16'd5);
    chk_out("R3", 1'b0); chk_cnt("R11", 16'd5);
    ticks(4); chk_out("R3", 1'b0); chk_cnt("R11", 16'd1);
    ticks(1); chk_out("R3", 1'b1); chk_cnt("R11", 16'd0);
    ticks(3); chk_out("R3", 1'b1); chk_cnt("R3", 16'd0);
  endtask

  task automatic t_mode1();
    gate = 1'b1;
    do_load(3'd1, 16'd4);
    ticks(2); chk_out("R4", 1'b0); chk_cnt("R4", 16'd2);
    gate_pulse(); chk_cnt("R4", 16'd4);
    @(negedge clk); gate = 1'b0;
    ticks(4); chk_out("R4", 1'b1); chk_cnt("R4", 16'd0);
    gate = 1'b1;
  endtask

  task automatic t_mode2();
    gate = 1'b1;
    do_load(3'd2, 16'd3);
    chk_out("R5", 1'b1); chk_cnt("R5", 16'd3);
    ticks(2); chk_out("R5", 1'b0); chk_cnt("R5", 16'd1);
    ticks(1); chk_out("R5", 1'b1); chk_cnt("R5", 16'd3);
    ticks(1); gate_pulse(); chk_cnt("R5", 16'd3); chk_out("R5", 1'b1);
    ticks(2); chk_out("R5", 1'b0);
  endtask

  task automatic t_mode3();
    gate = 1'b1;
    do_load(3'd3, 16'd5);
    ticks(2); chk_out("R6", 1'b1);
    ticks(1); chk_out("R6", 1'b0); chk_cnt("R6", 16'd2);
    ticks(1); chk_out("R6", 1'b0);
    ticks(1); chk_out("R6", 1'b1); chk_cnt("R6", 16'd5);
    ticks(1); gate_pulse(); chk_cnt("R6", 16'd5);
    do_load(3'd3, 16'd4);
    ticks(2); chk_out("R6", 1'b0);
  endtask

  task automatic t_mode4();
    gate = 1'b1;
    do_load(3'd4, 16'd3);
    ticks(2); chk_out("R7", 1'b0);
    ticks(1); chk_out("R7", 1'b1); chk_cnt("R7", 16'd0);
    ticks(1); chk_out("R7", 1'b0);
    ticks(3); chk_out("R7", 1'b0); chk_cnt("R7", 16'd0);
  endtask

  task automatic t_mode5();
    gate = 1'b1;
    do_load(3'd5, 16'd3);
    ticks(2); gate_pulse(); chk_cnt("R8", 16'd3);
    @(negedge clk); gate = 1'b0;
    ticks(2); chk_out("R8", 1'b0); chk_cnt("R8", 16'd1);
    ticks(1); chk_out("R8", 1'b1);
    ticks(1); chk_out("R8", 1'b0);
    gate = 1'b1;
  endtask

  task automatic t_gate_pause();
    gate = 1'b1;
    do_load(3'd3, 16'd5);
    @(negedge clk); gate = 1'b0;
    ticks(3); chk_cnt("R9", 16'd5); chk_out("R9", 1'b1);
    do_load(3'd0, 16'd6);
    ticks(2); chk_cnt("R9", 16'd6);
    do_load(3'd4, 16'd2);
    ticks(4); chk_out("R9", 1'b0); chk_cnt("R9", 16'd2);
    gate = 1'b1;
    ticks(2); chk_out("R9", 1'b1);
  endtask

  task automatic t_alias();
    gate = 1'b1;
    do_load(3'd6, 16'd3);
    ticks(2); chk_out("R2", 1'b0);
    ticks(1); chk_out("R2", 1'b1); chk_cnt("R2", 16'd3);
    do_load(3'd7, 16'd4);
    ticks(2); chk_out("R2", 1'b0); chk_cnt("R2", 16'd2);
    ticks(2); chk_out("R2", 1'b1);
  endtask

  task automatic t_reload();
    gate = 1'b1;
    do_load(3'd0, 16'd10);
    ticks(3); chk_cnt("R12", 16'd7);
    @(negedge clk);
    cnt_en = 1'b1; load = 1'b1; load_mode = 3'd0; load_count = 16'd2;
    @(negedge clk);
    cnt_en = 1'b0; load = 1'b0;
    chk_cnt("R12", 16'd2); chk_out("R12", 1'b0);
    ticks(2); chk_out("R12", 1'b1);
  endtask

  task automatic t_zero();
    gate = 1'b1;
    do_load(3'd0, 16'd0);
    chk_cnt("R1", 16'd0); chk_out("R1", 1'b0);
    ticks(65535); chk_out("R1", 1'b0); chk_cnt("R1", 16'd1);
    ticks(1); chk_out("R1", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_gate_pause();
    t_alias();
    t_reload();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule